// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects one nonmaskable request and seven maskable request lines and raises a single interrupt request toward the processor. It keeps an in-service flag for every maskable line. The processor is interrupted only when the best pending request outranks every line already being serviced. The nonmaskable input is always the most urgent. Among the maskable lines, line 0 ranks highest and line 6 lowest.

When the processor acknowledges, the block returns an 8-bit type code and marks the granted line as in service. Software ends a service routine by writing that line's type code to the end-of-interrupt address, which frees the line and everything below it. Two control registers can each turn one line into a cascade pair. In a cascade pair, the request line takes its type code from an external bus, and a neighbouring pin becomes an acknowledge strobe toward the external controller. Setting neither pair gives the fully nested mode. Setting the first pair gives one cascade pair. Setting both gives two pairs, and lines 4 to 6 then keep internal codes.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, `irq_o`, `vec_valid_o` and `inta_o` are low, every maskable line is masked (each control register reads 0x01), and the in-service register reads 0x00.
- R2: A maskable line passes through a two-flop synchronizer. A level held before rising edge n makes `irq_o` high after edge n+2. A line whose mask bit is 1 never raises `irq_o`.
- R3: A high `nmi_i` raises `irq_o` whatever the mask and in-service state. Its acknowledge returns type 0x02 and sets no in-service bit.
- R4: `irq_o` is high exactly when the nonmaskable input is active, or when the lowest-index unmasked pending line has a strictly lower index than the lowest-index in-service line. Re-entry from a line that is already in service and requests from lower-ranked lines raise nothing.
- R5: An `ack_i` cycle while `irq_o` is high produces a one-cycle `vec_valid_o` on the next cycle and sets the in-service bit of the granted line. An `ack_i` while `irq_o` is low is ignored.
- R6: A line without a cascade pair returns type 8 plus its index.
- R7: Writing 8+k (k < 7) to address 7 clears in-service bit k; any other value there changes nothing. If an acknowledge sets the same bit in that cycle, the set wins.
- R8: Bit 1 of the control register at address p (p = 0 or 1) makes line p a cascade line. Its type is the `ext_type_i` value sampled on the acknowledge cycle, `inta_o[p]` pulses together with `vec_valid_o`, and line p+2 is ignored.
- R9: The control register for line k is at address k, with bit 0 = mask and bit 1 = cascade (the cascade bit reads 0 except at addresses 0 and 1). The in-service register is at address 8, with bit k for line k. `rdata_o` holds the read value on the cycle after `rd_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_i | input | 1 | Nonmaskable request level |
| irq_i | input | 7 | Maskable request levels, index 0 highest |
| ack_i | input | 1 | Single-cycle acknowledge from the processor |
| ext_type_i | input | 8 | Type code from an external cascaded controller |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Type code valid strobe |
| vec_o | output | 8 | Interrupt type code |
| inta_o | output | 2 | Acknowledge strobes for the cascade pairs |

## Verification
An acknowledge and an end-of-interrupt write can land in the same cycle, so a single update of the in-service register has to both set one bit and clear another. The bench provokes this in two ways. In the first, the EOI write targets a different line from the one being granted, and both effects must appear. In the second, it targets the line being granted, and the set must win. Each case is judged by reading back the in-service register and by the `irq_o` level on every following cycle, both compared against the reference model.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int NPAIR     = 2;
  localparam int MASK_BIT  = 0;
  localparam int CAS_BIT   = 1;
endpackage

// File: rtl/nic_sync.sv
module nic_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q_o    <= '0;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
    end
  end
endmodule

// File: rtl/nic_prio.sv
module nic_prio #(
  parameter int N  = 7,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec_i[k]) begin
        any_o = 1'b1;
        idx_o = IW'(k);
      end
    end
  end
endmodule

// File: rtl/nic_regs.sv
module nic_regs
  import nic_pkg::*;
#(
  parameter int NSRC = 7,
  parameter int AW   = 4,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [1:0]      wbits_i,
  input  logic [NSRC-1:0] is_i,
  output logic [NSRC-1:0] mask_o,
  output logic [NPAIR-1:0] cas_o,
  output logic [DW-1:0]   rdata_o
);
  localparam logic [AW-1:0] IS_ADDR = AW'(NSRC + 1);

  logic [NSRC-1:0] cas_ext;
  logic [DW-1:0]   rd_mux;

  for (genvar k = 0; k < NSRC; k++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)                               mask_o[k] <= 1'b1;
      else if (wr_en_i && addr_i == AW'(k))  mask_o[k] <= wbits_i[MASK_BIT];
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_cas
    always_ff @(posedge clk) begin
      if (rst)                               cas_o[p] <= 1'b0;
      else if (wr_en_i && addr_i == AW'(p))  cas_o[p] <= wbits_i[CAS_BIT];
    end
  end

  assign cas_ext = NSRC'(cas_o);

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (addr_i == AW'(k)) rd_mux = DW'({cas_ext[k], mask_o[k]});
    end
    if (addr_i == IS_ADDR) rd_mux = DW'(is_i);
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NSRC     = 7,
  parameter int TW       = 8,
  parameter int AW       = 4,
  parameter int BASE_VEC = 8,
  parameter int NMI_VEC  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            nmi_i,
  input  logic [NSRC-1:0] irq_i,
  input  logic            ack_i,
  input  logic [TW-1:0]   ext_type_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [TW-1:0]   wdata_i,
  output logic [TW-1:0]   rdata_o,
  output logic            irq_o,
  output logic            vec_valid_o,
  output logic [TW-1:0]   vec_o,
  output logic [NPAIR-1:0] inta_o
);
  localparam int IW = $clog2(NSRC);
  localparam logic [AW-1:0] EOI_ADDR = AW'(NSRC);

  logic [NSRC:0]      sync_all;
  logic [NSRC-1:0]    req_s, mask, blocked, req_eff;
  logic               nmi_s;
  logic [NPAIR-1:0]   cas;
  logic [NSRC-1:0]    is_q, is_nxt, eoi_clr, ack_set;
  logic [TW-1:0]      eoi_off;
  logic               eoi_hit;
  logic [IW-1:0]      eoi_idx;
  logic               ack_take, win_cas;
  logic               r_any, s_any, irq_d;
  logic [IW-1:0]      r_idx, s_idx;
  logic [IW-1:0]      win_idx_q;
  logic               win_nmi_q;

  nic_sync #(.W(NSRC + 1)) u_sync (
    .clk (clk), .rst (rst), .d_i ({nmi_i, irq_i}), .q_o (sync_all)
  );
  assign req_s = sync_all[NSRC-1:0];
  assign nmi_s = sync_all[NSRC];

  nic_regs #(.NSRC(NSRC), .AW(AW), .DW(TW)) u_regs (
    .clk (clk), .rst (rst), .wr_en_i (wr_en_i), .rd_en_i (rd_en_i),
    .addr_i (addr_i), .wbits_i (wdata_i[1:0]), .is_i (is_q),
    .mask_o (mask), .cas_o (cas), .rdata_o (rdata_o)
  );

  // Cascade pair p turns line p+2 into an acknowledge pin
  always_comb begin
    blocked = '0;
    for (int p = 0; p < NPAIR; p++) blocked[p + NPAIR] = cas[p];
  end
  assign req_eff = req_s & ~mask & ~blocked;

  assign eoi_off = wdata_i - TW'(BASE_VEC);
  assign eoi_hit = wr_en_i && (addr_i == EOI_ADDR) && (eoi_off < TW'(NSRC));
  assign eoi_idx = IW'(eoi_off);
  assign eoi_clr = eoi_hit ? (NSRC'(1) << eoi_idx) : '0;

  assign ack_take = ack_i && irq_o;
  assign ack_set  = (ack_take && !win_nmi_q) ? (NSRC'(1) << win_idx_q) : '0;
  assign is_nxt   = (is_q & ~eoi_clr) | ack_set;

  nic_prio #(.N(NSRC)) u_req_prio (.vec_i (req_eff), .any_o (r_any), .idx_o (r_idx));
  nic_prio #(.N(NSRC)) u_is_prio  (.vec_i (is_nxt),  .any_o (s_any), .idx_o (s_idx));

  assign irq_d   = nmi_s || (r_any && (!s_any || r_idx < s_idx));
  assign win_cas = (win_idx_q < IW'(NPAIR)) && cas[win_idx_q[0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      is_q        <= '0;
      irq_o       <= 1'b0;
      win_idx_q   <= '0;
      win_nmi_q   <= 1'b0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
      inta_o      <= '0;
    end else begin
      is_q        <= is_nxt;
      irq_o       <= irq_d;
      win_idx_q   <= r_idx;
      win_nmi_q   <= nmi_s;
      vec_valid_o <= ack_take;
      inta_o      <= '0;
      if (ack_take) begin
        if (win_nmi_q) begin
          vec_o <= TW'(NMI_VEC);
        end else if (win_cas) begin
          vec_o  <= ext_type_i;
          inta_o <= NPAIR'(1) << win_idx_q[0];
        end else begin
          vec_o <= TW'(BASE_VEC) + TW'(win_idx_q);
        end
      end
    end
  end

  a_r3_nmi_raises: assert property (@(posedge clk) disable iff (rst)
    nmi_s |=> irq_o);
  a_r4_winner_not_in_service: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !win_nmi_q) |-> !is_q[win_idx_q]);
  a_r5_vec_from_ack: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> $past(ack_i && irq_o));
  a_r5_is_set: assert property (@(posedge clk) disable iff (rst)
    (ack_take && !win_nmi_q) |=> is_q[$past(win_idx_q)]);
  a_r7_eoi_clears: assert property (@(posedge clk) disable iff (rst)
    (eoi_hit && !ack_set[eoi_idx]) |=> !is_q[$past(eoi_idx)]);
  a_r8_inta_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inta_o));
  a_r8_inta_with_vec: assert property (@(posedge clk) disable iff (rst)
    (|inta_o) |-> vec_valid_o);
endmodule

// File: tb/nested_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nested_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nmi = 1'b0;
  logic [6:0] irq = '0;
  logic       ack = 1'b0;
  logic [7:0] ext = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vec;
  logic       irq_o, vv;
  logic [1:0] inta;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  nested_irq_ctrl dut_i (
    .clk (clk), .rst (rst), .nmi_i (nmi), .irq_i (irq), .ack_i (ack),
    .ext_type_i (ext), .wr_en_i (wr), .rd_en_i (rd), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq_o),
    .vec_valid_o (vv), .vec_o (vec), .inta_o (inta)
  );

  // Behavioural reference model
  logic [6:0] m_s1, m_s2, m_mask, m_is;
  logic       m_n1, m_n2, m_irq, m_winnmi, m_vv;
  logic [1:0] m_cas, m_inta;
  logic [7:0] m_vec;
  int         m_win;

  always @(posedge clk) begin : model
    logic [6:0] isn, r;
    int h, s;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_n1 = 0; m_n2 = 0; m_mask = '1; m_cas = '0;
      m_is = '0; m_irq = 0; m_winnmi = 0; m_win = 0; m_vv = 0; m_vec = '0; m_inta = '0;
    end else begin
      isn = m_is;
      if (wr && addr == 4'd7 && wdata >= 8 && wdata < 15) isn[wdata - 8] = 1'b0;
      m_vv = 0; m_inta = '0;
      if (ack && m_irq) begin
        m_vv = 1;
        if (m_winnmi) m_vec = 8'd2;
        else begin
          if (m_win < 2 && m_cas[m_win]) begin m_vec = ext; m_inta[m_win] = 1'b1; end
          else m_vec = 8'(8 + m_win);
          isn[m_win] = 1'b1;
        end
      end
      for (int k = 0; k < 7; k++)
        r[k] = m_s2[k] && !m_mask[k] && !(k == 2 && m_cas[0]) && !(k == 3 && m_cas[1]);
      h = 7; s = 7;
      for (int k = 6; k >= 0; k--) begin
        if (r[k]) h = k;
        if (isn[k]) s = k;
      end
      m_irq = m_n2 || (h < 7 && h < s);
      m_winnmi = m_n2;
      m_win = (h < 7) ? h : 0;
      m_is = isn;
      if (wr && addr < 4'd7) begin
        m_mask[addr] = wdata[0];
        if (addr < 4'd2) m_cas[addr[0]] = wdata[1];
      end
      m_s2 = m_s1; m_s1 = irq; m_n2 = m_n1; m_n1 = nmi;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(irq_o == m_irq, "R4", "irq_o vs model", irq_o, m_irq);
      chk(vv == m_vv, "R5", "vec_valid_o vs model", vv, m_vv);
      if (m_vv) chk(vec == m_vec, "R6", "vec_o vs model", vec, m_vec);
      chk(inta == m_inta, "R8", "inta_o vs model", inta, m_inta);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0;
    chk(rdata == exp, tag, "register read", rdata, exp);
  endtask

  task automatic do_ack(input logic [7:0] e, input logic [7:0] ev, input logic [1:0] ei, input string tag);
    @(negedge clk); ack = 1; ext = e;
    @(negedge clk); ack = 0;
    chk(vv == 1'b1, tag, "vec_valid after ack", vv, 1);
    chk(vec == ev, tag, "type code", vec, ev);
    chk(inta == ei, tag, "inta strobe", inta, ei);
  endtask

  initial begin
    idle(4);
    rst = 0; cmp_on = 1;
    @(negedge clk);
    chk(irq_o == 0 && vv == 0 && inta == 0, "R1", "outputs after reset", {irq_o, vv, inta}, 0);
    rreg(4'd0, 8'h01, "R1");
    rreg(4'd8, 8'h00, "R1");

    irq[4] = 1; idle(5);
    chk(irq_o == 0, "R2", "masked line silent", irq_o, 0);
    for (int k = 0; k < 7; k++) wreg(4'(k), 8'h00);
    idle(3);
    chk(irq_o == 1, "R2", "unmasked line raises", irq_o, 1);
    rreg(4'd4, 8'h00, "R9");

    do_ack(8'h00, 8'h0C, 2'b00, "R6");
    idle(2);
    chk(irq_o == 0, "R4", "re-entry blocked", irq_o, 0);
    rreg(4'd8, 8'h10, "R5");
    irq[5] = 1; idle(4);
    chk(irq_o == 0, "R4", "lower rank blocked", irq_o, 0);
    irq[1] = 1; idle(4);
    chk(irq_o == 1, "R4", "higher rank nests", irq_o, 1);
    do_ack(8'h00, 8'h09, 2'b00, "R4");
    rreg(4'd8, 8'h12, "R5");
    irq[1] = 0;
    wreg(4'd7, 8'h09); idle(3);
    rreg(4'd8, 8'h10, "R7");
    chk(irq_o == 0, "R7", "line 4 still in service", irq_o, 0);
    wreg(4'd7, 8'h40);
    rreg(4'd8, 8'h10, "R7");
    wreg(4'd7, 8'h0C); idle(3);
    chk(irq_o == 1, "R7", "line 4 re-enabled", irq_o, 1);
    do_ack(8'h00, 8'h0C, 2'b00, "R6");
    irq[4] = 0; irq[5] = 0;
    wreg(4'd7, 8'h0C); idle(3);
    rreg(4'd8, 8'h00, "R7");

    nmi = 1; idle(4);
    chk(irq_o == 1, "R3", "nmi raises", irq_o, 1);
    do_ack(8'h00, 8'h02, 2'b00, "R3");
    rreg(4'd8, 8'h00, "R3");
    nmi = 0; idle(4);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    chk(vv == 0, "R5", "stray ack ignored", vv, 0);

    wreg(4'd0, 8'h02);
    irq[2] = 1; idle(4);
    chk(irq_o == 0, "R8", "line 2 ignored in cascade", irq_o, 0);
    irq[0] = 1; idle(4);
    do_ack(8'h55, 8'h55, 2'b01, "R8");
    rreg(4'd0, 8'h02, "R9");
    rreg(4'd8, 8'h01, "R8");

    wreg(4'd1, 8'h02);
    irq[3] = 1; irq[1] = 1; irq[0] = 0;
    wreg(4'd7, 8'h08); idle(4);
    chk(irq_o == 1, "R8", "pair 1 request", irq_o, 1);
    do_ack(8'h66, 8'h66, 2'b10, "R8");
    irq[1] = 0;

    irq[0] = 1; idle(4);
    @(negedge clk); ack = 1; ext = 8'h77; wr = 1; addr = 4'd7; wdata = 8'h09;
    @(negedge clk); ack = 0; wr = 0;
    chk(vec == 8'h77 && vv, "R7", "ack with other-line EOI", vec, 8'h77);
    rreg(4'd8, 8'h01, "R7");
    wreg(4'd7, 8'h08); idle(3);
    @(negedge clk); ack = 1; wr = 1; addr = 4'd7; wdata = 8'h08;
    @(negedge clk); ack = 0; wr = 0;
    rreg(4'd8, 8'h01, "R7");
    irq = '0; idle(5);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule